// File: doc/BRIEF.md
# Distributed-Arithmetic Systolic FIR Filter

This block computes an unsigned inner product of N = P·M input samples with N fixed coefficients, without a multiplier. The taps are split into P groups of M taps. Each group has its own processing element (PE) with a 2^M-word table. The M-bit address of a PE is one bit plane of that group's samples, and each table word is the sum of the coefficients whose address bit is set. The PEs form a registered adder chain. Each PE adds its table word to the partial sum from its left neighbour, and the first PE takes zero on its left. One shift-accumulator at the end of the chain combines the bit planes into the result.

The upstream logic presents one bit plane per cycle, most significant bit first. The vector for PE p is delayed by p cycles relative to PE 0, so each plane meets its partial sum in the chain. A start strobe marks the cycle in which PE 0 receives the top plane of a word. A new word may start every L cycles. Each word yields one result, with a one-cycle valid pulse.

Top module: `da_fir_systolic`

## Requirements
- R1: Address bit m of PE p (`bits_i[p*M+m]`) carries a bit of the sample for tap k = p·M + m. The coefficient for tap k is (COEF_STEP·k + COEF_BASE) mod 2^CW, which is 3k+5 with the default parameters. When `valid_o` is high, `y_o` equals the sum over k of coefficient(k)·x_k.
- R2: Within a word, bit planes arrive from bit L-1 down to bit 0. The planes for PE p come one cycle after the same planes for PE p-1.
- R3: The result register is L + CW + M + ceil(log2 P) bits wide. Its value never wraps, including when every sample is all ones.
- R4: `valid_o` is first high in the cycle that lies L+P clock edges after the edge that samples `start_i`.
- R5: When words start every L cycles without gaps, one result is presented every L cycles, in the order the words started.
- R6: `valid_o` is high for one cycle per result and is never high in two consecutive cycles.
- R7: During and right after reset, `y_o` is 0 and `valid_o` is 0. A reset in the middle of a word discards that word.
- R8: Bit vectors applied without a start strobe and with no word in progress have no effect: `valid_o` stays low and `y_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Marks the cycle in which PE 0 receives the MSB plane of a new word |
| bits_i | input | P*M | Staggered bit-plane vectors, M bits for each PE |
| y_o | output | L+CW+M+ceil(log2 P) | Filter result, held until the next result |
| valid_o | output | 1 | One-cycle pulse when a new result is on `y_o` |

## Verification
Several kinds of sample sets pass through the filter as an unbroken stream: rising ramps, lone set bits at either end of the tap range, alternating all-ones and all-zeros samples, and mixed patterns. A wrong coefficient order, a swapped bit order or a broken stagger changes the results of these sets in different ways. A word with one nonzero sample on the last tap shows whether the last PE's delay and table mapping are right. A word of all-ones samples reaches the largest possible sum and exposes a result register that is too narrow. A single word after an idle gap, and stray bit vectors sent without a start strobe, separate the output timing from the input pattern. A reset in the middle of a word checks that its partial result is thrown away.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  function automatic longint unsigned tap_coef(int k, int step, int base, int cw);
    longint unsigned v;
    v = longint'(step) * longint'(k) + longint'(base);
    return v & ((64'd1 << cw) - 64'd1);
  endfunction

  // sum of coefficients in group p selected by address a
  function automatic longint unsigned table_word(int p, int a, int m_w,
                                                 int step, int base, int cw);
    longint unsigned s;
    s = 0;
    for (int m = 0; m < m_w; m++)
      if (((a >> m) & 1) == 1) s += tap_coef(m + p * m_w, step, base, cw);
    return s;
  endfunction

endpackage

// File: rtl/da_fir_pe.sv
module da_fir_pe #(
  parameter int M         = 4,
  parameter int CW        = 8,
  parameter int SW        = 13,
  parameter int PIDX      = 0,
  parameter int COEF_STEP = 3,
  parameter int COEF_BASE = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [M-1:0]  addr_i,
  input  logic [SW-1:0] left_i,
  output logic [SW-1:0] sum_o
);
  localparam int DEPTH = 1 << M;

  logic [SW-1:0] tbl [DEPTH];
  logic [SW-1:0] sum_q;

  for (genvar a = 0; a < DEPTH; a++) begin : g_tbl
    assign tbl[a] = SW'(da_fir_pkg::table_word(PIDX, a, M, COEF_STEP, COEF_BASE, CW));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= left_i + tbl[addr_i];
  end

  assign sum_o = sum_q;

  // chain partial sum never wraps below its left input
  assert_chain_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sum_q >= $past(left_i));

endmodule

// File: rtl/da_fir_acc.sv
module da_fir_acc #(
  parameter int L  = 8,
  parameter int P  = 2,
  parameter int SW = 13,
  parameter int AW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] chain_i,
  output logic [AW-1:0] y_o,
  output logic          valid_o
);
  localparam int CNTW = $clog2(L) + 1;

  logic [P-1:0]    dly_q;
  logic [AW-1:0]   acc_q;
  logic [CNTW-1:0] cnt_q;
  logic            act_q, vld_q;
  logic            win;

  assign win = dly_q[P-1];  // window start aligned to chain latency

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      dly_q <= P'({dly_q, start_i});
      vld_q <= act_q && !win && (cnt_q == CNTW'(L - 1));
      if (win) begin
        acc_q <= AW'(chain_i);
        cnt_q <= CNTW'(1);
        act_q <= 1'b1;
      end else if (act_q) begin
        acc_q <= (acc_q << 1) + AW'(chain_i);
        if (cnt_q == CNTW'(L - 1)) begin
          act_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign y_o     = acc_q;
  assign valid_o = vld_q;

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
  assert_valid_after_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(act_q));
  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> cnt_q < CNTW'(L));
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !win) |=> {1'b0, acc_q} >= ({1'b0, $past(acc_q)} << 1));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !win) |=> $stable(acc_q));

endmodule

// File: rtl/da_fir_systolic.sv
module da_fir_systolic #(
  parameter int P         = 2,
  parameter int M         = 4,
  parameter int L         = 8,
  parameter int CW        = 8,
  parameter int COEF_STEP = 3,
  parameter int COEF_BASE = 5,
  localparam int SW = CW + M + $clog2(P),
  localparam int AW = L + SW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [P*M-1:0]  bits_i,
  output logic [AW-1:0]   y_o,
  output logic            valid_o
);
  logic [SW-1:0] link [P+1];

  assign link[0] = '0;

  for (genvar p = 0; p < P; p++) begin : g_pe
    da_fir_pe #(
      .M(M), .CW(CW), .SW(SW), .PIDX(p),
      .COEF_STEP(COEF_STEP), .COEF_BASE(COEF_BASE)
    ) pe_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .addr_i(bits_i[p*M +: M]),
      .left_i(link[p]),
      .sum_o (link[p+1])
    );
  end

  da_fir_acc #(.L(L), .P(P), .SW(SW), .AW(AW)) acc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .chain_i(link[P]),
    .y_o    (y_o),
    .valid_o(valid_o)
  );

  assert_reset_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !valid_o);

endmodule

// File: tb/da_fir_systolic_tb_top.sv
module da_fir_systolic_tb_top;
  localparam int P = 2, M = 4, L = 8, CW = 8, N = P * M;
  localparam int AW = L + CW + M + 1;
  localparam int NV = 6;
  localparam int WMAX = 8;

  // sample k of a word sits in bits [8k+7:8k]
  localparam logic [63:0] VEC [NV] = '{
    64'h0102030405060708, 64'h8000000000000001, 64'hFF00FF00FF00FF00,
    64'h00000000000000FF, 64'h5A5AA5A5C33C0FF0, 64'h0000000000000000
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [P*M-1:0] bits = '0;
  logic [AW-1:0]  y;
  logic           valid;
  logic [7:0]     xs [WMAX][N];
  int n_chk = 0, n_bad = 0, cyc_all = 0;

  always #2 clk = ~clk;

  da_fir_systolic dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bits_i(bits),
    .y_o(y), .valid_o(valid)
  );

  function automatic longint exp_y(int w);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(3 * k + 5) * longint'(xs[w][k]);
    return s;
  endfunction

  task automatic check(string req, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // drives w_cnt words back to back and checks every output cycle
  task automatic run_stream(int w_cnt);
    int total = w_cnt * L + P + L + 2;
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      if (c >= L + P && (c - L - P) % L == 0 && (c - L - P) / L < w_cnt) begin
        int w = (c - L - P) / L;
        check(w == 0 ? "R4 first valid" : "R5 valid cadence", longint'(valid), 1);
        check("R1 result", longint'(y), exp_y(w));
      end else if (valid) begin
        check("R6 stray valid", 1, 0);
      end
      start = (c % L == 0) && (c / L < w_cnt);
      for (int p = 0; p < P; p++) begin
        int j = c - p;
        for (int m = 0; m < M; m++) begin
          if (j >= 0 && j / L < w_cnt) bits[p*M+m] = xs[j/L][p*M+m][L-1-(j%L)];  // R2 MSB first, staggered
          else bits[p*M+m] = 1'b0;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_all);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    repeat (3) @(negedge clk);
    check("R7 reset y", longint'(y), 0);
    check("R7 reset valid", longint'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: continuous stream
    for (int w = 0; w < NV; w++)
      for (int k = 0; k < N; k++) xs[w][k] = VEC[w][8*k +: 8];
    run_stream(NV);

    // R2: lone sample on last tap, after idle gap
    for (int k = 0; k < N; k++) xs[0][k] = (k == N - 1) ? 8'h81 : 8'h00;
    repeat (5) @(negedge clk);
    run_stream(1);

    // R3: all ones reach maximum sum
    for (int w = 0; w < 2; w++) for (int k = 0; k < N; k++) xs[w][k] = 8'hFF;
    run_stream(2);
    check("R3 max sum", longint'(y), 31620);

    // R8: bits without start
    held = y;
    bits = '1;
    for (int c = 0; c < 3 * L; c++) begin
      @(negedge clk);
      if (valid) check("R8 no valid", 1, 0);
    end
    check("R8 y held", longint'(y), longint'(held));
    bits = '0;

    // R7: reset mid word discards it
    for (int k = 0; k < N; k++) xs[0][k] = 8'h33;
    start = 1'b1; bits = '1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 mid-word reset y", longint'(y), 0);
    rst_n = 1'b1; bits = '0;
    for (int c = 0; c < 2 * L; c++) begin
      @(negedge clk);
      if (valid) check("R7 no valid after reset", 1, 0);
    end
    check("R7 y after reset", longint'(y), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule